// File: doc/BRIEF.md
# Ethernet Transmit Stop and Pause Sequencer

This block is the transmit-side control unit of a 10/100 Ethernet MAC. It decides, cycle by cycle, whether the transmitter may start a data frame, must start a MAC Control PAUSE frame, or has to wait. It does not move frame data. It sees a frame-available flag from the transmit FIFO and a frame-done strobe from the serializer, and it returns one-cycle start strobes to them.

Software drives the block through one 32-bit control register on a simple register bus. The register holds five fields: a graceful stop request, a heartbeat enable, a full-duplex enable, a PAUSE transmission request that hardware clears, and a read-only flag that is high while a received PAUSE frame holds the transmitter off. Data frames are held back by either of two gates, the software stop and the received-pause timer. A requested PAUSE frame still goes out while either gate is closed. When heartbeat checking is enabled, a window opens after each end of transmission and a status output is set if no collision shows up inside it.

The sequencer has seven states. ST_IDLE waits for work. ST_DATA covers a data frame in flight. ST_PAUSE_REQ is one cycle that raises the stop-complete interrupt before a PAUSE frame. ST_PAUSE_SEND is one cycle that issues the PAUSE start strobe. ST_PAUSE_BUSY waits for that frame to finish. ST_STOP_ACK is one cycle that raises the interrupt on a graceful stop. ST_STOPPED holds the transmitter.

The transitions, with their priorities:
- ST_IDLE goes to ST_PAUSE_REQ on a pending PAUSE request. Failing that, it goes to ST_STOP_ACK on stop. Failing that, it goes to ST_DATA, with a start strobe, when a frame is available and the gates are open.
- ST_DATA goes to ST_STOP_ACK on an early collision while stop is set, and marks the frame for retry. On frame done it goes to ST_PAUSE_REQ, ST_STOP_ACK or ST_IDLE, in that order of priority.
- ST_PAUSE_REQ always goes to ST_PAUSE_SEND, and ST_PAUSE_SEND always goes to ST_PAUSE_BUSY.
- ST_PAUSE_BUSY, on frame done, goes to ST_STOPPED if stop is set and to ST_IDLE otherwise.
- ST_STOP_ACK always goes to ST_STOPPED.
- ST_STOPPED goes to ST_PAUSE_SEND on a PAUSE request. Once stop is cleared, it goes to ST_DATA with a retransmit strobe if a retry is pending and the gates are open, or to ST_IDLE if no retry is pending.

Top module: `eth_tx_flow_ctrl`

## Requirements
- R1: After reset the control register reads zero, and start_data, start_pause, retransmit, stop_irq and hb_status are all low.
- R2: The control register is at byte offset 0xC4. Its fields are bit 0 stop, bit 1 heartbeat enable, bit 2 full-duplex, bit 3 PAUSE request and bit 4 received-pause status. Bits 31:5 and bit 4 ignore writes, and bits 31:5 read as zero. Any other address reads zero.
- R3: In ST_IDLE with no stop, no PAUSE request, no received pause and a frame available (and, in half duplex, no carrier or collision), start_data is high in that same cycle for exactly one cycle.
- R4: Setting stop while idle raises stop_irq for one cycle, one cycle after the register write takes effect, and no data frame starts while stop is set.
- R5: Setting stop during a data frame leaves stop_irq low until frame_done. stop_irq then rises in the next cycle. Clearing stop lets the next available frame start.
- R6: An early collision during a data frame while stop is set halts the frame and raises stop_irq in the next cycle. Once stop is cleared, retransmit and start_data pulse together in the first cycle after the register write takes effect.
- R7: A PAUSE request set during a data frame waits for frame_done, then raises stop_irq for one cycle, then start_pause for one cycle. When the PAUSE frame's frame_done arrives, hardware clears bit 3 and data frames resume in the next cycle.
- R8: A PAUSE request is honoured while stop holds the transmitter (start_pause comes two cycles after the write with no second interrupt, and the block returns to the stopped state) and while a received pause is active.
- R9: In full duplex, a received-pause strobe with a non-zero quanta count sets bit 4 for quanta × CYC_PER_QUANTUM cycles and blocks data frames. A new strobe reloads the count, and a quanta count of zero ends the pause at once. In half duplex the strobe is ignored.
- R10: With full-duplex set, frames start regardless of carrier_sense and collision. With it clear, no frame starts while carrier_sense or collision is high.
- R11: With heartbeat enabled, frame_done opens a window of HB_WIN cycles and clears hb_status. If collision stays low for the whole window, hb_status is set. A collision inside the window leaves it clear.
- R12: Writes to bits 1 and 2 are ignored while mac_en is high and take effect while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_en | input | 1 | MAC enabled; locks duplex and heartbeat fields |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| frame_avail | input | 1 | Transmit FIFO holds a frame |
| frame_done | input | 1 | Current frame finished |
| early_col | input | 1 | Early collision during the current frame |
| carrier_sense | input | 1 | Carrier present on the medium |
| collision | input | 1 | Collision input |
| rx_pause_valid | input | 1 | A PAUSE frame was received |
| rx_pause_quanta | input | QUANTA_W | Pause length of the received frame in quanta |
| start_data | output | 1 | Start a data frame (one cycle) |
| start_pause | output | 1 | Start a MAC Control PAUSE frame (one cycle) |
| retransmit | output | 1 | The data start is a resend of a halted frame |
| stop_irq | output | 1 | Graceful-stop-complete interrupt pulse |
| hb_status | output | 1 | Heartbeat missing |

## Verification
The bench builds the block with CYC_PER_QUANTUM set to 4 and HB_WIN set to 8, in place of 512 and 64. With these values a received pause expires, a reload lengthens it and a heartbeat window closes within a dozen cycles, so the exact last cycle of each can be checked. The remaining parameters keep their defaults, so the register offset and the 16-bit quanta path are the same as in the shipped configuration.

// File: rtl/eth_txc_pkg.sv
package eth_txc_pkg;

    localparam int FIELD_W  = 5;
    localparam int B_STOP   = 0;
    localparam int B_HB     = 1;
    localparam int B_FDX    = 2;
    localparam int B_PREQ   = 3;
    localparam int B_RXP    = 4;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_DATA       = 3'd1,
        ST_PAUSE_REQ  = 3'd2,
        ST_PAUSE_SEND = 3'd3,
        ST_PAUSE_BUSY = 3'd4,
        ST_STOP_ACK   = 3'd5,
        ST_STOPPED    = 3'd6
    } txc_state_t;

endpackage

// File: rtl/eth_txc_regs.sv
module eth_txc_regs
    import eth_txc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mac_en,
    input  logic              sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              pause_clr,
    input  logic              rx_paused,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              stop_q,
    output logic              hb_en_q,
    output logic              fdx_q,
    output logic              preq_q
);

    logic              wr_hit;
    logic [FIELD_W-1:0] fields;
    logic              wdata_unused;

    assign wr_hit       = bus_wr && sel;
    assign wdata_unused = ^{bus_wdata[DATA_W-1:FIELD_W], bus_wdata[B_RXP]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q  <= 1'b0;
            hb_en_q <= 1'b0;
            fdx_q   <= 1'b0;
            preq_q  <= 1'b0;
        end else begin
            if (wr_hit) begin
                stop_q <= bus_wdata[B_STOP];
                preq_q <= bus_wdata[B_PREQ];
                if (!mac_en) begin
                    hb_en_q <= bus_wdata[B_HB];
                    fdx_q   <= bus_wdata[B_FDX];
                end
            end
            if (pause_clr) begin
                preq_q <= 1'b0;
            end
        end
    end

    always_comb begin
        fields         = '0;
        fields[B_STOP] = stop_q;
        fields[B_HB]   = hb_en_q;
        fields[B_FDX]  = fdx_q;
        fields[B_PREQ] = preq_q;
        fields[B_RXP]  = rx_paused;
        bus_rdata      = sel ? DATA_W'(fields) : '0;
    end

endmodule

// File: rtl/eth_txc_pause_tmr.sv
module eth_txc_pause_tmr #(
    parameter int QUANTA_W        = 16,
    parameter int CYC_PER_QUANTUM = 512
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [QUANTA_W-1:0] quanta,
    output logic                paused
);

    localparam int PRE_W = (CYC_PER_QUANTUM > 1) ? $clog2(CYC_PER_QUANTUM) : 1;

    logic [QUANTA_W-1:0] qcnt;
    logic                tick;

    generate
        if (CYC_PER_QUANTUM > 1) begin : gen_prescale
            localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CYC_PER_QUANTUM - 1);
            logic [PRE_W-1:0] pre;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre <= '0;
                end else if (load || tick) begin
                    pre <= PRE_MAX;
                end else if (paused) begin
                    pre <= pre - 1'b1;
                end
            end
            assign tick = paused && (pre == '0);
        end else begin : gen_direct
            assign tick = paused;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paused <= 1'b0;
            qcnt   <= '0;
        end else if (load) begin
            paused <= (quanta != '0);
            qcnt   <= quanta;
        end else if (tick) begin
            if (qcnt == QUANTA_W'(1)) begin
                paused <= 1'b0;
            end
            qcnt <= qcnt - 1'b1;
        end
    end

endmodule

// File: rtl/eth_txc_hbeat.sv
module eth_txc_hbeat #(
    parameter int HB_WIN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tx_end,
    input  logic collision,
    output logic hb_err
);

    localparam int CNT_W = (HB_WIN > 1) ? $clog2(HB_WIN) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HB_WIN - 1);

    logic             open_q;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            cnt    <= '0;
            hb_err <= 1'b0;
        end else if (tx_end && enable) begin
            open_q <= 1'b1;
            cnt    <= CNT_TOP;
            hb_err <= 1'b0;
        end else if (open_q) begin
            if (collision) begin
                open_q <= 1'b0;
            end else if (cnt == '0) begin
                open_q <= 1'b0;
                hb_err <= 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

endmodule

// File: rtl/eth_txc_fsm.sv
module eth_txc_fsm
    import eth_txc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop,
    input  logic fdx,
    input  logic preq,
    input  logic rx_paused,
    input  logic frame_avail,
    input  logic frame_done,
    input  logic early_col,
    input  logic carrier_sense,
    input  logic collision,
    output logic start_data,
    output logic start_pause,
    output logic retransmit,
    output logic stop_irq,
    output logic pause_clr,
    output logic tx_end
);

    txc_state_t state_q, state_d;
    logic       retry_q, retry_d;
    logic       can_go;

    assign can_go = !rx_paused && (fdx || (!carrier_sense && !collision));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            retry_q <= 1'b0;
        end else begin
            state_q <= state_d;
            retry_q <= retry_d;
        end
    end

    always_comb begin
        state_d = state_q;
        retry_d = retry_q;
        unique case (state_q)
            ST_IDLE: begin
                if (preq)                           state_d = ST_PAUSE_REQ;
                else if (stop)                      state_d = ST_STOP_ACK;
                else if (frame_avail && can_go)     state_d = ST_DATA;
            end
            ST_DATA: begin
                if (early_col && stop) begin
                    state_d = ST_STOP_ACK;
                    retry_d = 1'b1;
                end else if (frame_done) begin
                    if (preq)      state_d = ST_PAUSE_REQ;
                    else if (stop) state_d = ST_STOP_ACK;
                    else           state_d = ST_IDLE;
                end
            end
            ST_PAUSE_REQ:  state_d = ST_PAUSE_SEND;
            ST_PAUSE_SEND: state_d = ST_PAUSE_BUSY;
            ST_PAUSE_BUSY: begin
                if (frame_done) state_d = stop ? ST_STOPPED : ST_IDLE;
            end
            ST_STOP_ACK:   state_d = ST_STOPPED;
            ST_STOPPED: begin
                if (preq) begin
                    state_d = ST_PAUSE_SEND;
                end else if (!stop) begin
                    if (!retry_q) begin
                        state_d = ST_IDLE;
                    end else if (can_go) begin
                        state_d = ST_DATA;
                        retry_d = 1'b0;
                    end
                end
            end
            default:       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        start_data  = 1'b0;
        start_pause = 1'b0;
        retransmit  = 1'b0;
        stop_irq    = 1'b0;
        pause_clr   = 1'b0;
        tx_end      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start_data = !preq && !stop && frame_avail && can_go;
            end
            ST_DATA: begin
                tx_end = frame_done && !(early_col && stop);
            end
            ST_PAUSE_REQ: begin
                stop_irq = 1'b1;
            end
            ST_PAUSE_SEND: begin
                start_pause = 1'b1;
            end
            ST_PAUSE_BUSY: begin
                pause_clr = frame_done;
                tx_end    = frame_done;
            end
            ST_STOP_ACK: begin
                stop_irq = 1'b1;
            end
            ST_STOPPED: begin
                retransmit = !preq && !stop && retry_q && can_go;
                start_data = retransmit;
            end
            default: begin
                start_data = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/eth_tx_flow_ctrl.sv
module eth_tx_flow_ctrl
    import eth_txc_pkg::*;
#(
    parameter int          ADDR_W          = 8,
    parameter int          DATA_W          = 32,
    parameter int unsigned CTRL_OFFSET     = 32'hC4,
    parameter int          QUANTA_W        = 16,
    parameter int          CYC_PER_QUANTUM = 512,
    parameter int          HB_WIN          = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mac_en,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                frame_avail,
    input  logic                frame_done,
    input  logic                early_col,
    input  logic                carrier_sense,
    input  logic                collision,
    input  logic                rx_pause_valid,
    input  logic [QUANTA_W-1:0] rx_pause_quanta,
    output logic                start_data,
    output logic                start_pause,
    output logic                retransmit,
    output logic                stop_irq,
    output logic                hb_status
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(CTRL_OFFSET);

    logic reg_sel;
    logic stop_q, hb_en_q, fdx_q, preq_q;
    logic rx_paused;
    logic pause_clr;
    logic tx_end;

    assign reg_sel = (bus_addr == HIT_ADDR);

    eth_txc_regs #(
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .mac_en   (mac_en),
        .sel      (reg_sel),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .pause_clr(pause_clr),
        .rx_paused(rx_paused),
        .bus_rdata(bus_rdata),
        .stop_q   (stop_q),
        .hb_en_q  (hb_en_q),
        .fdx_q    (fdx_q),
        .preq_q   (preq_q)
    );

    eth_txc_pause_tmr #(
        .QUANTA_W       (QUANTA_W),
        .CYC_PER_QUANTUM(CYC_PER_QUANTUM)
    ) u_pause (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rx_pause_valid && fdx_q),
        .quanta(rx_pause_quanta),
        .paused(rx_paused)
    );

    eth_txc_hbeat #(
        .HB_WIN(HB_WIN)
    ) u_hb (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (hb_en_q),
        .tx_end   (tx_end),
        .collision(collision),
        .hb_err   (hb_status)
    );

    eth_txc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .stop         (stop_q),
        .fdx          (fdx_q),
        .preq         (preq_q),
        .rx_paused    (rx_paused),
        .frame_avail  (frame_avail),
        .frame_done   (frame_done),
        .early_col    (early_col),
        .carrier_sense(carrier_sense),
        .collision    (collision),
        .start_data   (start_data),
        .start_pause  (start_pause),
        .retransmit   (retransmit),
        .stop_irq     (stop_irq),
        .pause_clr    (pause_clr),
        .tx_end       (tx_end)
    );

endmodule

// File: rtl/eth_txc_chk.sv
module eth_txc_chk (
    input logic clk,
    input logic rst_n,
    input logic mac_en,
    input logic bus_wr,
    input logic reg_sel,
    input logic stop_q,
    input logic fdx_q,
    input logic hb_en_q,
    input logic rx_paused,
    input logic carrier_sense,
    input logic collision,
    input logic start_data,
    input logic start_pause,
    input logic retransmit,
    input logic stop_irq
);

    AST_NO_DATA_WHILE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        start_data |-> !stop_q); // R4

    AST_NO_DATA_WHILE_RXP: assert property (@(posedge clk) disable iff (!rst_n)
        start_data |-> !rx_paused); // R9

    AST_HALF_DUPLEX_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (start_data && !fdx_q) |-> (!carrier_sense && !collision)); // R10

    AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_data && start_pause)); // R7

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |=> !stop_irq); // R5

    AST_RETX_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
        retransmit |-> start_data); // R6

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && reg_sel && mac_en) |=> ($stable(fdx_q) && $stable(hb_en_q))); // R12

endmodule

bind eth_tx_flow_ctrl eth_txc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mac_en       (mac_en),
    .bus_wr       (bus_wr),
    .reg_sel      (reg_sel),
    .stop_q       (stop_q),
    .fdx_q        (fdx_q),
    .hb_en_q      (hb_en_q),
    .rx_paused    (rx_paused),
    .carrier_sense(carrier_sense),
    .collision    (collision),
    .start_data   (start_data),
    .start_pause  (start_pause),
    .retransmit   (retransmit),
    .stop_irq     (stop_irq)
);

// File: tb/eth_tx_flow_ctrl_tb_top.sv
module eth_tx_flow_ctrl_tb_top;

    localparam int CLK_P = 10;
    localparam int QW    = 16;
    localparam logic [3:0] EV_IRQ   = 4'b0001;
    localparam logic [3:0] EV_DATA  = 4'b0010;
    localparam logic [3:0] EV_PAUSE = 4'b0100;
    localparam logic [3:0] EV_RETX  = 4'b1010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mac_en = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = 8'hC4;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          frame_avail = 1'b0;
    logic          frame_done = 1'b0;
    logic          early_col = 1'b0;
    logic          carrier_sense = 1'b0;
    logic          collision = 1'b0;
    logic          rx_pause_valid = 1'b0;
    logic [QW-1:0] rx_pause_quanta = '0;
    logic          start_data, start_pause, retransmit, stop_irq, hb_status;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    logic [3:0] exp_code[$];
    string      exp_tag[$];

    always #(CLK_P/2) clk = ~clk;

    eth_tx_flow_ctrl #(
        .CYC_PER_QUANTUM(4),
        .HB_WIN         (8)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .mac_en         (mac_en),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .frame_avail    (frame_avail),
        .frame_done     (frame_done),
        .early_col      (early_col),
        .carrier_sense  (carrier_sense),
        .collision      (collision),
        .rx_pause_valid (rx_pause_valid),
        .rx_pause_quanta(rx_pause_quanta),
        .start_data     (start_data),
        .start_pause    (start_pause),
        .retransmit     (retransmit),
        .stop_irq       (stop_irq),
        .hb_status      (hb_status)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_ev(logic [3:0] code, string tag);
        exp_code.push_back(code);
        exp_tag.push_back(tag);
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic wr(logic [31:0] v);
        tick();
        bus_wr    = 1'b1;
        bus_wdata = v;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic pulse_done();
        tick();
        frame_done = 1'b1;
        tick();
        frame_done = 1'b0;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (rst_n && !done && ({retransmit, start_pause, start_data, stop_irq} != 4'b0)) begin
                logic [3:0] got;
                got = {retransmit, start_pause, start_data, stop_irq};
                checks++;
                if (exp_code.size() == 0) begin
                    failures++;
                    $display("FAIL unexpected event R3 actual=%0h expected=none", got);
                end else begin
                    logic [3:0] e;
                    string      t;
                    e = exp_code.pop_front();
                    t = exp_tag.pop_front();
                    if (got !== e) begin
                        failures++;
                        $display("FAIL event %s actual=%0h expected=%0h", t, got, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // reset state R1
        tick(3);
        chk("R1 reg", bus_rdata, 32'h0);
        chk("R1 outs", {27'b0, start_data, start_pause, retransmit, stop_irq, hb_status}, 32'h0);
        rst_n = 1'b1;
        tick();
        chk("R1 after release", bus_rdata, 32'h0);

        // register map R2, lock R12
        wr(32'hFFFF_FFF4);
        settle();
        chk("R2 reserved and ro bits", bus_rdata, 32'h4);
        bus_addr = 8'h00;
        settle();
        chk("R2 other address", bus_rdata, 32'h0);
        bus_addr = 8'hC4;
        mac_en = 1'b1;
        wr(32'h2);
        settle();
        chk("R12 locked write", bus_rdata, 32'h4);

        // full duplex start ignoring carrier R3 R10
        carrier_sense = 1'b1;
        expect_ev(EV_DATA, "R10 fdx start");
        tick();
        frame_avail = 1'b1;
        settle();
        chk("R3 start same cycle", start_data, 1);
        tick();
        frame_avail = 1'b0;
        settle();
        chk("R3 single pulse", start_data, 0);
        tick(2);
        pulse_done();
        carrier_sense = 1'b0;
        tick();

        // stop while idle R4, restart R5
        expect_ev(EV_IRQ, "R4 idle stop irq");
        wr(32'h5);
        settle();
        chk("R4 irq not yet", stop_irq, 0);
        tick();
        chk("R4 irq", stop_irq, 1);
        frame_avail = 1'b1;
        settle();
        chk("R4 no start", start_data, 0);
        tick(3);
        chk("R4 still held", start_data, 0);
        expect_ev(EV_DATA, "R5 restart");
        wr(32'h4);
        tick();
        chk("R5 restart start", start_data, 1);
        tick();
        frame_avail = 1'b0;
        pulse_done();
        tick();

        // stop during frame R5
        expect_ev(EV_DATA, "R5 frame");
        tick();
        frame_avail = 1'b1;
        tick();
        frame_avail = 1'b0;
        wr(32'h5);
        tick(2);
        chk("R5 irq waits", stop_irq, 0);
        expect_ev(EV_IRQ, "R5 irq after done");
        pulse_done();
        settle();
        chk("R5 irq after done", stop_irq, 1);
        wr(32'h4);
        tick(2);

        // early collision with stop R6
        expect_ev(EV_DATA, "R6 frame");
        tick();
        frame_avail = 1'b1;
        tick();
        frame_avail = 1'b0;
        wr(32'h5);
        tick();
        expect_ev(EV_IRQ, "R6 irq");
        early_col = 1'b1;
        tick();
        early_col = 1'b0;
        settle();
        chk("R6 halt irq", stop_irq, 1);
        tick(2);
        expect_ev(EV_RETX, "R6 resend");
        wr(32'h4);
        settle();
        chk("R6 retransmit", {retransmit, start_data}, 2'b11);
        tick();
        chk("R6 retransmit pulse", retransmit, 0);
        pulse_done();
        tick();

        // pause request during frame R7
        expect_ev(EV_DATA, "R7 frame");
        tick();
        frame_avail = 1'b1;
        tick();
        wr(32'hC);
        settle();
        chk("R7 request visible", bus_rdata, 32'hC);
        expect_ev(EV_IRQ, "R7 irq");
        expect_ev(EV_PAUSE, "R7 pause");
        pulse_done();
        settle();
        chk("R7 irq", stop_irq, 1);
        tick();
        chk("R7 start pause", {start_pause, start_data}, 2'b10);
        tick(3);
        chk("R7 bit held", bus_rdata, 32'hC);
        expect_ev(EV_DATA, "R7 resume");
        pulse_done();
        settle();
        chk("R7 hw clear", bus_rdata, 32'h4);
        chk("R7 resume", start_data, 1);
        tick();
        frame_avail = 1'b0;
        pulse_done();
        tick();

        // pause request while stopped R8
        expect_ev(EV_IRQ, "R8 stop");
        wr(32'h5);
        tick(2);
        expect_ev(EV_PAUSE, "R8 pause while stopped");
        wr(32'hD);
        tick();
        chk("R8 start pause", start_pause, 1);
        tick(2);
        pulse_done();
        settle();
        chk("R8 back to stopped", bus_rdata, 32'h5);
        wr(32'h4);
        tick(2);

        // received pause timing R9
        rx_pause_quanta = 16'd3;
        tick();
        rx_pause_valid = 1'b1;
        tick();
        rx_pause_valid = 1'b0;
        settle();
        chk("R9 status set", bus_rdata[4], 1);
        for (int k = 2; k <= 12; k++) tick();
        chk("R9 last paused cycle", bus_rdata[4], 1);
        tick();
        chk("R9 expiry", bus_rdata[4], 0);

        // reload R9
        rx_pause_quanta = 16'd2;
        tick();
        rx_pause_valid = 1'b1;
        tick();
        rx_pause_valid = 1'b0;
        tick(2);
        rx_pause_valid = 1'b1;
        tick();
        rx_pause_valid = 1'b0;
        tick(5);
        chk("R9 reload extends", bus_rdata[4], 1);
        tick(2);
        chk("R9 reload last", bus_rdata[4], 1);
        tick();
        chk("R9 reload end", bus_rdata[4], 0);

        // pause request while rx paused R8, zero quanta R9
        rx_pause_quanta = 16'd10;
        tick();
        rx_pause_valid = 1'b1;
        tick();
        rx_pause_valid = 1'b0;
        frame_avail = 1'b1;
        tick(3);
        chk("R9 data held", start_data, 0);
        expect_ev(EV_IRQ, "R8 irq under rx pause");
        expect_ev(EV_PAUSE, "R8 pause under rx pause");
        wr(32'hC);
        tick();
        chk("R8 irq", stop_irq, 1);
        tick();
        chk("R8 pause under rx pause", start_pause, 1);
        pulse_done();
        tick(2);
        chk("R9 still held", start_data, 0);
        expect_ev(EV_DATA, "R9 zero quanta");
        rx_pause_quanta = 16'd0;
        tick();
        rx_pause_valid = 1'b1;
        tick();
        rx_pause_valid = 1'b0;
        settle();
        chk("R9 zero ends", bus_rdata[4], 0);
        chk("R9 data after zero", start_data, 1);
        tick();
        frame_avail = 1'b0;
        pulse_done();
        tick();

        // half duplex R10 R12, ignored rx pause R9
        mac_en = 1'b0;
        wr(32'h2);
        settle();
        chk("R12 unlocked write", bus_rdata, 32'h2);
        mac_en = 1'b1;
        carrier_sense = 1'b1;
        frame_avail = 1'b1;
        tick(3);
        chk("R10 defer on carrier", start_data, 0);
        rx_pause_quanta = 16'd5;
        rx_pause_valid = 1'b1;
        tick();
        rx_pause_valid = 1'b0;
        settle();
        chk("R9 ignored half duplex", bus_rdata[4], 0);
        expect_ev(EV_DATA, "R10 carrier drop");
        carrier_sense = 1'b0;
        settle();
        chk("R10 start on idle medium", start_data, 1);
        tick();
        frame_avail = 1'b0;
        tick();

        // heartbeat missing R11
        pulse_done();
        chk("R11 window open", hb_status, 0);
        tick(7);
        chk("R11 last window cycle", hb_status, 0);
        tick();
        chk("R11 missing heartbeat", hb_status, 1);

        // heartbeat present R11
        expect_ev(EV_DATA, "R11 frame");
        tick();
        frame_avail = 1'b1;
        tick();
        frame_avail = 1'b0;
        pulse_done();
        settle();
        chk("R11 cleared at window", hb_status, 0);
        tick(2);
        collision = 1'b1;
        tick();
        collision = 1'b0;
        tick(9);
        chk("R11 heartbeat seen", hb_status, 0);

        tick(4);
        chk("R3 scoreboard drained", exp_code.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule